// File: doc/BRIEF.md
# Shadowed SRAM with Store/Recall Sequencer

This block is a byte-wide static RAM in which every storage row has a nonvolatile twin. A host reaches it through a chip-enable, output-enable and write-enable port sampled on a clock. Read and write paths work like a plain SRAM. A separate path copies the whole working array into the twin (save) or brings the twin back into the working array (restore). Each copy moves one full row per clock.

No dedicated command pin exists. A detector watches the addresses of successive qualified reads. Five shared addresses followed by a sixth, operation-selecting address start a save or a restore. A write, or a read of any other address, sends the detector back to the beginning. While a copy runs, `busy` is high, the data bus is never driven and writes are dropped. A restore first zeroes every working row and then loads the twin. Reset starts a restore on its own, so the working array comes up holding the saved image.

Top module: `nvsram_ctrl`

## Requirements
- R1: Reset starts a restore. `busy` is 1 during reset and for 2*NROWS clock cycles after its release (64 with defaults). After that, every word reads back the value saved by the last save.
- R2: A read (`ce_n`=0, `we_n`=1, `oe_n`=0) at clock edge k sets `dq_drive`=1 and puts the word at `addr` on `dq_rd` after edge k.
- R3: With `ce_n`=1, or with `oe_n`=1 during a read, `dq_drive` is 0 and `dq_rd` is 0 after the edge. A cycle with `ce_n`=1 changes no stored word.
- R4: A write (`ce_n`=0, `we_n`=0) stores `dq_wr` at `addr`, and a later read returns it.
- R5: Qualified reads of SEQ0..SEQ4 (defaults 0x0E, 0x38, 0xC7, 0x1F, 0x70) followed by a read of SEQ_STORE (0xFC) start a save. `busy` is then high for NROWS+STORE_WAIT cycles (36 with defaults), and the twin takes the whole working array.
- R6: The same five reads followed by SEQ_RECALL (0x4C) start a restore. The working array is cleared and then loaded from the twin, so earlier overwrites are undone. A restore leaves the twin unchanged, so a second restore gives the same contents.
- R7: A write, or a qualified read of a non-matching address, inside the sequence aborts it. The final address then starts nothing (`busy` stays 0), and a complete fresh sequence is needed.
- R8: While `busy` is 1, reads leave `dq_drive` at 0, writes change nothing, and reads of sequence addresses do not advance the detector.
- R9: Cycles with `ce_n`=1 between sequence steps neither advance nor abort the sequence. A read with `oe_n`=1 counts as a step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; starts a restore |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Word address |
| dq_wr | input | DATA_W | Write data |
| dq_rd | output | DATA_W | Read data, 0 when not driven |
| dq_drive | output | 1 | High when the bus would be driven |
| busy | output | 1 | A row copy (save, restore or post-save wait) is running |

## Verification
The assertions assume the port signals are steady around the sampling edge and that `rst_n` alone brings the block back to its restore state. The bench drives every input on the falling clock edge and samples outputs one falling edge later, so each access takes exactly one rising edge. Transfers are started only through the full address sequence. Accesses issued during `busy` are placed after the launching read has been sampled.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
    typedef enum logic [2:0] {
        XS_CLEAR,
        XS_LOAD,
        XS_SAVE,
        XS_SETTLE,
        XS_IDLE
    } xfer_state_e;

    localparam int SEQ_COMMON = 5;
endpackage

// File: rtl/nvs_seq_detect.sv
module nvs_seq_detect #(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] SEQ0 = 8'h0E,
    parameter logic [ADDR_W-1:0] SEQ1 = 8'h38,
    parameter logic [ADDR_W-1:0] SEQ2 = 8'hC7,
    parameter logic [ADDR_W-1:0] SEQ3 = 8'h1F,
    parameter logic [ADDR_W-1:0] SEQ4 = 8'h70,
    parameter logic [ADDR_W-1:0] SEQ_STORE  = 8'hFC,
    parameter logic [ADDR_W-1:0] SEQ_RECALL = 8'h4C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_acc_i,
    input  logic              wr_acc_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              save_go_o,
    output logic              load_go_o
);
    import nvs_pkg::*;

    typedef struct packed {
        logic [2:0] step;
    } det_t;

    det_t cur_q, nxt_d;
    logic [ADDR_W-1:0] want;

    always_comb begin
        case (cur_q.step)
            3'd0:    want = SEQ0;
            3'd1:    want = SEQ1;
            3'd2:    want = SEQ2;
            3'd3:    want = SEQ3;
            default: want = SEQ4;
        endcase
    end

    always_comb begin
        nxt_d     = cur_q;
        save_go_o = 1'b0;
        load_go_o = 1'b0;
        if (wr_acc_i) begin
            nxt_d.step = 3'd0;
        end else if (rd_acc_i) begin
            if (cur_q.step == 3'(SEQ_COMMON)) begin
                save_go_o  = (addr_i == SEQ_STORE);
                load_go_o  = (addr_i == SEQ_RECALL);
                nxt_d.step = 3'd0;
            end else if (addr_i == want) begin
                nxt_d.step = cur_q.step + 3'd1;
            end else begin
                nxt_d.step = 3'd0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    // R7: a write inside the sequence sends the detector back to its start
    p_write_aborts_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_acc_i |=> (cur_q.step == 3'd0));

    // R9: an idle (deselected) cycle leaves the step count alone
    p_idle_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_acc_i && !wr_acc_i) |=> $stable(cur_q.step));
endmodule

// File: rtl/nvs_xfer_seq.sv
module nvs_xfer_seq #(
    parameter int NROWS      = 32,
    parameter int STORE_WAIT = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     save_go_i,
    input  logic                     load_go_i,
    output logic                     clr_en_o,
    output logic                     cpy_en_o,
    output logic                     sto_en_o,
    output logic [$clog2(NROWS)-1:0] row_o,
    output logic                     busy_o
);
    import nvs_pkg::*;

    localparam int RIDX_W = $clog2(NROWS);
    localparam int WAIT_W = $clog2(STORE_WAIT + 2);
    localparam logic [RIDX_W-1:0] LAST_ROW = RIDX_W'(NROWS - 1);

    typedef struct packed {
        xfer_state_e       st;
        logic [RIDX_W-1:0] row;
        logic [WAIT_W-1:0] wcnt;
    } seq_t;

    seq_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        case (cur_q.st)
            XS_CLEAR: begin
                nxt_d.row = cur_q.row + 1'b1;
                if (cur_q.row == LAST_ROW) nxt_d.st = XS_LOAD;
            end
            XS_LOAD: begin
                nxt_d.row = cur_q.row + 1'b1;
                if (cur_q.row == LAST_ROW) nxt_d.st = XS_IDLE;
            end
            XS_SAVE: begin
                nxt_d.row  = cur_q.row + 1'b1;
                nxt_d.wcnt = '0;
                if (cur_q.row == LAST_ROW)
                    nxt_d.st = (STORE_WAIT > 0) ? XS_SETTLE : XS_IDLE;
            end
            XS_SETTLE: begin
                nxt_d.wcnt = cur_q.wcnt + 1'b1;
                if (cur_q.wcnt == WAIT_W'(STORE_WAIT - 1)) nxt_d.st = XS_IDLE;
            end
            default: begin
                nxt_d.row = '0;
                if (save_go_i)      nxt_d.st = XS_SAVE;
                else if (load_go_i) nxt_d.st = XS_CLEAR;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.st   <= XS_CLEAR;
            cur_q.row  <= '0;
            cur_q.wcnt <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign clr_en_o = (cur_q.st == XS_CLEAR);
    assign cpy_en_o = (cur_q.st == XS_LOAD);
    assign sto_en_o = (cur_q.st == XS_SAVE);
    assign row_o    = cur_q.row;
    assign busy_o   = (cur_q.st != XS_IDLE);

    // R5: a detected save sequence launches a save at row zero
    p_save_launch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && save_go_i) |=> (sto_en_o && row_o == '0));

    // R6: a detected restore sequence begins with the clearing pass
    p_load_launch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && load_go_i) |=> (clr_en_o && row_o == '0));

    // R1: the clearing pass is always followed by the loading pass
    p_clear_then_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en_o && row_o == LAST_ROW) |=> (cpy_en_o && row_o == '0));
endmodule

// File: rtl/nvs_arrays.sv
module nvs_arrays #(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 8,
    parameter int ROW_BYTES = 8
) (
    input  logic              clk,
    input  logic                                     clr_en_i,
    input  logic                                     cpy_en_i,
    input  logic                                     sto_en_i,
    input  logic [ADDR_W-$clog2(ROW_BYTES)-1:0]      xfer_row_i,
    input  logic                                     wr_en_i,
    input  logic [ADDR_W-1:0]                        addr_i,
    input  logic [DATA_W-1:0]                        wdata_i,
    output logic [DATA_W-1:0]                        rd_byte_o
);
    localparam int COL_W  = $clog2(ROW_BYTES);
    localparam int RIDX_W = ADDR_W - COL_W;
    localparam int NROWS  = 1 << RIDX_W;
    localparam int ROW_W  = ROW_BYTES * DATA_W;

    logic [ROW_W-1:0] work_q   [NROWS];
    logic [ROW_W-1:0] shadow_q [NROWS];

    logic [RIDX_W-1:0] a_row;
    logic [COL_W-1:0]  a_col;

    assign a_row = addr_i[ADDR_W-1:COL_W];
    assign a_col = addr_i[COL_W-1:0];

    // The arrays are storage, not control state, so they are written
    // directly rather than through a next-value struct.
    always_ff @(posedge clk) begin
        for (int r = 0; r < NROWS; r++) begin
            if (clr_en_i && xfer_row_i == RIDX_W'(r))
                work_q[r] <= '0;
            else if (cpy_en_i && xfer_row_i == RIDX_W'(r))
                work_q[r] <= shadow_q[r];
            else if (wr_en_i && a_row == RIDX_W'(r))
                work_q[r][a_col*DATA_W +: DATA_W] <= wdata_i;

            if (sto_en_i && xfer_row_i == RIDX_W'(r))
                shadow_q[r] <= work_q[r];
        end
    end

    assign rd_byte_o = work_q[a_row][a_col*DATA_W +: DATA_W];

    // R8: a host write is never requested while a row transfer is running
    p_no_host_write_in_xfer_r8: assert property (@(posedge clk)
        (clr_en_i || cpy_en_i || sto_en_i) |-> !wr_en_i);
endmodule

// File: rtl/nvsram_ctrl.sv
module nvsram_ctrl #(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 8,
    parameter int ROW_BYTES  = 8,
    parameter int STORE_WAIT = 4,
    parameter logic [ADDR_W-1:0] SEQ0 = 8'h0E,
    parameter logic [ADDR_W-1:0] SEQ1 = 8'h38,
    parameter logic [ADDR_W-1:0] SEQ2 = 8'hC7,
    parameter logic [ADDR_W-1:0] SEQ3 = 8'h1F,
    parameter logic [ADDR_W-1:0] SEQ4 = 8'h70,
    parameter logic [ADDR_W-1:0] SEQ_STORE  = 8'hFC,
    parameter logic [ADDR_W-1:0] SEQ_RECALL = 8'h4C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dq_wr,
    output logic [DATA_W-1:0] dq_rd,
    output logic              dq_drive,
    output logic              busy
);
    localparam int COL_W  = $clog2(ROW_BYTES);
    localparam int RIDX_W = ADDR_W - COL_W;
    localparam int NROWS  = 1 << RIDX_W;

    typedef struct packed {
        logic              drive;
        logic [DATA_W-1:0] data;
    } port_t;

    port_t out_q, out_d;

    logic rd_acc, wr_acc;
    logic save_go, load_go;
    logic clr_en, cpy_en, sto_en;
    logic [RIDX_W-1:0] xfer_row;
    logic [DATA_W-1:0] rd_byte;

    assign rd_acc = !ce_n && we_n  && !busy;
    assign wr_acc = !ce_n && !we_n && !busy;

    nvs_seq_detect #(
        .ADDR_W(ADDR_W), .SEQ0(SEQ0), .SEQ1(SEQ1), .SEQ2(SEQ2),
        .SEQ3(SEQ3), .SEQ4(SEQ4), .SEQ_STORE(SEQ_STORE), .SEQ_RECALL(SEQ_RECALL)
    ) u_detect (
        .clk(clk), .rst_n(rst_n), .rd_acc_i(rd_acc), .wr_acc_i(wr_acc),
        .addr_i(addr), .save_go_o(save_go), .load_go_o(load_go)
    );

    nvs_xfer_seq #(.NROWS(NROWS), .STORE_WAIT(STORE_WAIT)) u_xfer (
        .clk(clk), .rst_n(rst_n), .save_go_i(save_go), .load_go_i(load_go),
        .clr_en_o(clr_en), .cpy_en_o(cpy_en), .sto_en_o(sto_en),
        .row_o(xfer_row), .busy_o(busy)
    );

    nvs_arrays #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ROW_BYTES(ROW_BYTES)) u_arrays (
        .clk(clk), .clr_en_i(clr_en), .cpy_en_i(cpy_en), .sto_en_i(sto_en),
        .xfer_row_i(xfer_row), .wr_en_i(wr_acc), .addr_i(addr),
        .wdata_i(dq_wr), .rd_byte_o(rd_byte)
    );

    always_comb begin
        out_d.drive = rd_acc && !oe_n;
        out_d.data  = out_d.drive ? rd_byte : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign dq_rd    = out_q.data;
    assign dq_drive = out_q.drive;

    // R8: nothing is driven in the cycle after a transfer cycle
    p_busy_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !dq_drive);

    // R3: a deselected cycle leaves the bus undriven and zero
    p_deselect_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> (!dq_drive && dq_rd == '0));
endmodule

// File: tb/nvsram_ctrl_bench.sv
module nvsram_ctrl_bench;
    localparam int NROWS     = 32;
    localparam int STORE_WAIT = 4;
    localparam int NVEC      = 8;
    // {address, data} pairs written, saved and later restored
    localparam logic [15:0] VEC [NVEC] = '{
        16'h00_A5, 16'h07_3C, 16'h08_81, 16'h55_7E,
        16'h9B_01, 16'hC8_FF, 16'hE1_5A, 16'hFF_C3
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [7:0] addr = '0, dq_wr = '0;
    logic [7:0] dq_rd;
    logic       dq_drive, busy;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    nvsram_ctrl u_nvsram_ctrl (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .dq_wr(dq_wr), .dq_rd(dq_rd), .dq_drive(dq_drive), .busy(busy)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] a, input logic [7:0] d);
        ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; addr = a; dq_wr = d;
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1;
    endtask

    task automatic do_read(input logic [7:0] a, input logic oe,
                           output logic [7:0] d, output logic drv);
        ce_n = 1'b0; we_n = 1'b1; oe_n = oe; addr = a;
        @(negedge clk);
        d = dq_rd; drv = dq_drive;
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic prefix(input logic gap);
        logic [7:0] d; logic v;
        logic [7:0] s [5] = '{8'h0E, 8'h38, 8'hC7, 8'h1F, 8'h70};
        for (int i = 0; i < 5; i++) begin
            do_read(s[i], 1'b1, d, v);
            if (gap) idle(2);
        end
    endtask

    task automatic count_busy(output int n);
        n = 0;
        while (busy && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic read_check(input string req, input logic [7:0] a, input logic [7:0] e);
        logic [7:0] d; logic v;
        do_read(a, 1'b0, d, v);
        chk(req, v, 1);
        chk(req, d, e);
    endtask

    initial begin
        repeat (10000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] d; logic v; int n;
        // Reset state: busy high (restore), bus quiet
        @(negedge clk); @(negedge clk);
        chk("R1 busy in reset", busy, 1);
        chk("R3 no drive in reset", dq_drive, 0);
        rst_n = 1'b1;
        count_busy(n);
        chk("R1 restore length after reset", n, 2 * NROWS);

        // R4/R2: table of writes, then read-backs
        for (int i = 0; i < NVEC; i++) do_write(VEC[i][15:8], VEC[i][7:0]);
        for (int i = 0; i < NVEC; i++) read_check("R2 R4 table read", VEC[i][15:8], VEC[i][7:0]);

        // R3: oe_n high read and deselect leave the bus undriven
        do_read(8'h07, 1'b1, d, v);
        chk("R3 oe_n high drive", v, 0);
        chk("R3 oe_n high data", d, 0);
        ce_n = 1'b1; we_n = 1'b0; addr = 8'h07; dq_wr = 8'h00;
        @(negedge clk);
        we_n = 1'b1;
        chk("R3 deselect drive", dq_drive, 0);
        read_check("R3 deselect no write", 8'h07, 8'h3C);

        // R5 with R9: save with idle gaps between steps
        prefix(1'b1);
        do_read(8'hFC, 1'b1, d, v);
        chk("R5 save starts busy", busy, 1);
        // R8: accesses during the save are ignored
        do_write(8'h00, 8'h11);
        chk("R8 no drive during busy", dq_drive, 0);
        do_read(8'h00, 1'b0, d, v);
        chk("R8 read during busy undriven", v, 0);
        count_busy(n);
        chk("R5 save busy length", n + 2, NROWS + STORE_WAIT);
        read_check("R8 write during busy dropped", 8'h00, 8'hA5);

        // Overwrite, then restore (R6)
        for (int i = 0; i < NVEC; i++) do_write(VEC[i][15:8], ~VEC[i][7:0]);
        read_check("R4 overwrite visible", VEC[3][15:8], ~VEC[3][7:0]);
        prefix(1'b0);
        do_read(8'h4C, 1'b1, d, v);
        chk("R6 restore starts busy", busy, 1);
        count_busy(n);
        chk("R6 restore busy length", n, 2 * NROWS);
        for (int i = 0; i < NVEC; i++) read_check("R6 restored data", VEC[i][15:8], VEC[i][7:0]);

        // R6: twin unchanged, second restore gives the same data
        do_write(VEC[5][15:8], 8'h00);
        prefix(1'b0);
        do_read(8'h4C, 1'b1, d, v);
        count_busy(n);
        read_check("R6 repeat restore", VEC[5][15:8], VEC[5][7:0]);

        // R7: write inside the sequence aborts it
        do_write(8'h55, 8'h99);
        prefix(1'b0);
        do_write(8'h08, 8'h81);
        do_read(8'hFC, 1'b1, d, v);
        chk("R7 write aborts", busy, 0);
        // R7: wrong read after three steps aborts
        do_read(8'h0E, 1'b1, d, v); do_read(8'h38, 1'b1, d, v); do_read(8'hC7, 1'b1, d, v);
        do_read(8'h20, 1'b1, d, v);
        do_read(8'h1F, 1'b1, d, v); do_read(8'h70, 1'b1, d, v);
        do_read(8'h4C, 1'b1, d, v);
        chk("R7 wrong read aborts", busy, 0);
        read_check("R7 no restore happened", 8'h55, 8'h99);

        // R8: sequence reads during busy do not advance the detector
        prefix(1'b0);
        do_read(8'hFC, 1'b1, d, v);
        prefix(1'b0);
        do_read(8'h4C, 1'b1, d, v);
        count_busy(n);
        idle(1);
        chk("R8 sequence during busy ignored", busy, 0);

        // R1: a second reset restores the last saved image (0x55 = 0x99)
        do_write(8'h55, 8'h00);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        count_busy(n);
        chk("R1 restore length after second reset", n, 2 * NROWS);
        read_check("R1 saved image after reset", 8'h55, 8'h99);
        read_check("R1 saved image after reset", 8'hFF, 8'hC3);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule